// File: doc/BRIEF.md
# Receive FIFO DMA Watermark Trigger

This block decides when the receive path should ask the bus DMA engine to start moving a frame out of the receive FIFO. It counts the bytes of the current frame as the FIFO accepts them and raises a request level once the frame has enough bytes and the early-collision and runt conditions are settled. A frame-start strobe begins a new count. A strobe marking a frame as complete and valid can raise the request early.

A 2-bit watermark in a small control register selects the byte threshold. Without runt acceptance, and always in half duplex, the byte-count path never requests before 64 bytes, which covers the slot window where collisions can still occur. With runt acceptance, a complete valid frame of any length raises the request. Once raised, the request holds until the drain engine reports that the frame is out or a new frame begins.

Top module: `rx_dma_wmark_top`

## Requirements
- R1: After reset, dma_req_o is 0, frame_bytes_o is 0, the watermark field is 10b and cfg_rdata_o reads 4'b1110.
- R2: The watermark is cfg_rdata_o[1:0]. It is written from cfg_wdata_i[1:0] when cfg_wr_i is high and either cfg_stop_i or cfg_suspend_i is high. Otherwise the write is ignored. The encoding is 00b=16, 01b=32, 10b=64 and 11b=112 bytes.
- R3: cfg_rdata_o[3:2] always read 11b, whatever was written to cfg_wdata_i[3:2].
- R4: On the edge that samples frame_start_i, frame_bytes_o becomes 1 if byte_wr_i is also high, and 0 otherwise. Each other sampled byte_wr_i adds 1. The count saturates at 2047.
- R5: With runt_accept_i low, in either duplex mode, dma_req_o rises on the edge after frame_bytes_o first reaches the larger of the watermark and 64.
- R6: In full duplex (half_duplex_i low) with runt_accept_i high, dma_req_o rises on the edge after frame_bytes_o reaches the watermark, even when the watermark is below 64.
- R7: In half duplex with runt_accept_i high, the byte-count path still waits for the larger of the watermark and 64.
- R8: dma_req_o rises on the edge that samples frame_done_i in two cases: when runt_accept_i is high, at any length, and when frame_bytes_o is at least 64. A shorter frame completing with runt_accept_i low does not raise it.
- R9: Once high, dma_req_o stays high until an edge that samples frame_start_i or drain_done_i. Such an edge clears it, taking priority over any raise condition.
- R10: After an edge that samples drain_done_i, dma_req_o is not raised again until after the next frame_start_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 4 | Control register write data |
| cfg_stop_i | input | 1 | Controller stopped, unlocks writes |
| cfg_suspend_i | input | 1 | Controller suspended, unlocks writes |
| cfg_rdata_o | output | 4 | Control register read value |
| half_duplex_i | input | 1 | Link runs half duplex |
| runt_accept_i | input | 1 | Accept frames shorter than 64 bytes |
| frame_start_i | input | 1 | New frame begins |
| byte_wr_i | input | 1 | One byte of the frame entered the FIFO |
| frame_done_i | input | 1 | Frame completed and is valid |
| drain_done_i | input | 1 | DMA drained the frame |
| frame_bytes_o | output | 11 | Bytes counted in the current frame |
| dma_req_o | output | 1 | Receive DMA request level |

## Verification
A corrupted byte count shows on frame_bytes_o at the next edge, and it moves the edge where dma_req_o rises relative to the strobe that crossed the threshold. A wrong watermark or mode decode shows as a request one or more edges early or late, or as a request in half duplex before byte 64. A lost clear or a lost drain-suppress flag shows as dma_req_o staying high, or returning, after the edge that should have cleared it. Because every byte, strobe and clear is compared at the following edge, each of these faults is seen within one clock of the stimulus that exposes it.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  parameter int unsigned CNT_W      = 11;
  parameter int unsigned WM_W       = 2;
  parameter int unsigned RES_W      = 2;
  parameter int unsigned SLOT_BYTES = 64;

  function automatic logic [CNT_W-1:0] wm_bytes(input logic [WM_W-1:0] code);
    logic [CNT_W-1:0] v;
    case (code)
      2'b00:   v = CNT_W'(16);
      2'b01:   v = CNT_W'(32);
      2'b10:   v = CNT_W'(64);
      default: v = CNT_W'(112);
    endcase
    return v;
  endfunction
endpackage

// File: rtl/rxw_cfg_reg.sv
module rxw_cfg_reg #(
  parameter int unsigned WM_W  = rxw_pkg::WM_W,
  parameter int unsigned RES_W = rxw_pkg::RES_W,
  localparam int unsigned REG_W = WM_W + RES_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             unlock_i,
  output logic [WM_W-1:0]  wm_o,
  output logic [REG_W-1:0] rdata_o
);
  localparam logic [WM_W-1:0] WM_RST = WM_W'(2);

  logic [WM_W-1:0] wm_q;
  logic            unused_res;

  assign unused_res = ^wdata_i[REG_W-1:WM_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                wm_q <= WM_RST;
    else if (wr_i && unlock_i)  wm_q <= wdata_i[WM_W-1:0];
  end

  assign wm_o    = wm_q;
  assign rdata_o = {{RES_W{1'b1}}, wm_q};

  p_wm_locked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !unlock_i) |=> $stable(wm_o));
  p_wm_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && unlock_i) |=> (wm_o == $past(wdata_i[WM_W-1:0])));
  p_res_ones_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&rdata_o[REG_W-1:WM_W]));
endmodule

// File: rtl/rxw_byte_cnt.sv
module rxw_byte_cnt #(
  parameter int unsigned CNT_W = rxw_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             byte_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (start_i)                     cnt_q <= CNT_W'(byte_i);
    else if (byte_i && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_cnt_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !byte_i) |=> (cnt_o == '0));
  p_cnt_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && byte_i && cnt_o != CNT_MAX) |=> (cnt_o == $past(cnt_o) + 1'b1));
  p_cnt_sat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && cnt_o == CNT_MAX) |=> (cnt_o == CNT_MAX));
endmodule

// File: rtl/rxw_req_ctrl.sv
module rxw_req_ctrl #(
  parameter int unsigned CNT_W      = rxw_pkg::CNT_W,
  parameter int unsigned WM_W       = rxw_pkg::WM_W,
  parameter int unsigned SLOT_BYTES = rxw_pkg::SLOT_BYTES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [WM_W-1:0]  wm_i,
  input  logic             start_i,
  input  logic             done_i,
  input  logic             drain_i,
  input  logic             half_duplex_i,
  input  logic             runt_accept_i,
  output logic             req_o
);
  localparam logic [CNT_W-1:0] SLOT = CNT_W'(SLOT_BYTES);

  logic [CNT_W-1:0] thr, eff, limit;
  logic             hit_lvl, hit_end, set_req;
  logic             req_q, served_q;

  // slot qualification dominates unless full duplex with runt accept
  always_comb begin
    thr     = rxw_pkg::wm_bytes(wm_i);
    eff     = (thr > SLOT) ? thr : SLOT;
    limit   = (runt_accept_i && !half_duplex_i) ? thr : eff;
    hit_lvl = (cnt_i >= limit);
    hit_end = done_i && (runt_accept_i || cnt_i >= SLOT);
    set_req = !served_q && (hit_lvl || hit_end);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q    <= 1'b0;
      served_q <= 1'b0;
    end else if (start_i) begin
      req_q    <= 1'b0;
      served_q <= 1'b0;
    end else if (drain_i) begin
      req_q    <= 1'b0;
      served_q <= 1'b1;
    end else if (set_req) begin
      req_q    <= 1'b1;
    end
  end

  assign req_o = req_q;

  p_clear_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !req_o);
  p_clear_drain_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_i |=> !req_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !start_i && !drain_i) |=> req_o);
  p_rise_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> ($past(done_i) || $past(cnt_i) >= CNT_W'(16)));
  p_hd_slot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(req_o) && $past(half_duplex_i) && !$past(done_i)) |-> ($past(cnt_i) >= SLOT));
  p_no_runt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(req_o) && !$past(runt_accept_i)) |-> ($past(cnt_i) >= SLOT));
endmodule

// File: rtl/rx_dma_wmark_top.sv
module rx_dma_wmark_top #(
  parameter int unsigned CNT_W      = rxw_pkg::CNT_W,
  parameter int unsigned WM_W       = rxw_pkg::WM_W,
  parameter int unsigned RES_W      = rxw_pkg::RES_W,
  parameter int unsigned SLOT_BYTES = rxw_pkg::SLOT_BYTES,
  localparam int unsigned REG_W     = WM_W + RES_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_wr_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  input  logic             cfg_stop_i,
  input  logic             cfg_suspend_i,
  output logic [REG_W-1:0] cfg_rdata_o,
  input  logic             half_duplex_i,
  input  logic             runt_accept_i,
  input  logic             frame_start_i,
  input  logic             byte_wr_i,
  input  logic             frame_done_i,
  input  logic             drain_done_i,
  output logic [CNT_W-1:0] frame_bytes_o,
  output logic             dma_req_o
);
  logic [WM_W-1:0]  wm;
  logic [CNT_W-1:0] cnt;

  rxw_cfg_reg #(.WM_W(WM_W), .RES_W(RES_W)) i_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (cfg_wr_i),
    .wdata_i  (cfg_wdata_i),
    .unlock_i (cfg_stop_i | cfg_suspend_i),
    .wm_o     (wm),
    .rdata_o  (cfg_rdata_o)
  );

  rxw_byte_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (frame_start_i),
    .byte_i  (byte_wr_i),
    .cnt_o   (cnt)
  );

  rxw_req_ctrl #(.CNT_W(CNT_W), .WM_W(WM_W), .SLOT_BYTES(SLOT_BYTES)) i_req (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cnt_i         (cnt),
    .wm_i          (wm),
    .start_i       (frame_start_i),
    .done_i        (frame_done_i),
    .drain_i       (drain_done_i),
    .half_duplex_i (half_duplex_i),
    .runt_accept_i (runt_accept_i),
    .req_o         (dma_req_o)
  );

  assign frame_bytes_o = cnt;

  p_rst_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!rst_ni) && !$past(frame_start_i) && !$past(byte_wr_i)) |-> (frame_bytes_o == '0));
endmodule

// File: tb/test_rx_dma_wmark_top.sv
module test_rx_dma_wmark_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 0, cfg_stop = 0, cfg_susp = 0;
  logic [3:0]  cfg_wdata = '0;
  logic [3:0]  cfg_rdata;
  logic        hd = 0, ra = 0, fs = 0, bw = 0, fd = 0, dd = 0;
  logic [10:0] bytes;
  logic        req;

  int errors = 0;
  int checks = 0;

  // reference model state
  logic [1:0]  m_wm = 2'b10;
  int          m_cnt = 0;
  logic        m_req = 0, m_served = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_dma_wmark_top i_rx_dma_wmark_top (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata), .cfg_stop_i(cfg_stop),
    .cfg_suspend_i(cfg_susp), .cfg_rdata_o(cfg_rdata),
    .half_duplex_i(hd), .runt_accept_i(ra),
    .frame_start_i(fs), .byte_wr_i(bw), .frame_done_i(fd), .drain_done_i(dd),
    .frame_bytes_o(bytes), .dma_req_o(req)
  );

  function automatic int wm_val(input logic [1:0] c);
    case (c)
      2'b00: return 16;
      2'b01: return 32;
      2'b10: return 64;
      default: return 112;
    endcase
  endfunction

  function automatic int req_limit();
    int t = wm_val(m_wm);
    int e = (t > 64) ? t : 64;
    return (ra && !hd) ? t : e;
  endfunction

  function automatic string mode_tag();
    if (m_served) return "R10";
    if (ra && !hd) return "R6";
    if (ra) return "R7";
    return "R5";
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock with the given strobes; model updated from pre-edge state
  task automatic cyc(input logic b, input logic s, input logic d, input logic dr, input string tag);
    logic set;
    bw = b; fs = s; fd = d; dd = dr;
    set = !m_served && ((m_cnt >= req_limit()) || (d && (ra || m_cnt >= 64)));
    if (s) begin m_req = 0; m_served = 0; end
    else if (dr) begin m_req = 0; m_served = 1; end
    else if (set) m_req = 1;
    if (s) m_cnt = b ? 1 : 0;
    else if (b && m_cnt < 2047) m_cnt++;
    @(posedge clk);
    @(negedge clk);
    bw = 0; fs = 0; fd = 0; dd = 0;
    check(tag, int'(req), int'(m_req));
    check("R4", int'(bytes), m_cnt);
  endtask

  task automatic cfg_write(input logic [3:0] w, input logic stp, input logic sus, input string tag);
    cfg_wr = 1; cfg_wdata = w; cfg_stop = stp; cfg_susp = sus;
    if (stp || sus) m_wm = w[1:0];
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 0; cfg_stop = 0; cfg_susp = 0;
    check(tag, int'(cfg_rdata), int'({2'b11, m_wm}));
  endtask

  task automatic run_frame(input int len, input bit valid, input int drain_at);
    int got = 0;
    int k = 0;
    cyc(0, 1, 0, 0, "R9");
    while (got < len) begin
      logic b = ($urandom_range(0, 3) != 0);
      if (b) got++;
      k++;
      cyc(b, 0, 0, (k == drain_at), (k == drain_at) ? "R9" : mode_tag());
    end
    if (valid) cyc(0, 0, 1, 0, "R8");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, mode_tag());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", int'(req), 0);
    check("R1", int'(bytes), 0);
    check("R1", int'(cfg_rdata), 4'b1110);

    // locked write ignored, unlocked writes land, reserved stay ones
    cfg_write(4'b0001, 0, 0, "R2");
    cfg_write(4'b0000, 1, 0, "R3");
    cfg_write(4'b0111, 0, 1, "R2");

    // R5: 112 threshold, no runt accept, full duplex
    hd = 0; ra = 0;
    run_frame(120, 1, 0);
    // R6: 16-byte watermark reached early in full duplex with runt accept
    cfg_write(4'b0000, 1, 0, "R2");
    ra = 1; hd = 0;
    run_frame(20, 0, 0);
    // R7: same watermark in half duplex waits for 64
    hd = 1;
    run_frame(70, 0, 0);
    // R8: short valid frame, runt accept raises at done
    run_frame(10, 1, 0);
    // R8: short valid frame without runt accept stays low
    ra = 0;
    run_frame(10, 1, 0);
    // R10: drain mid frame suppresses any further raise
    ra = 1; hd = 0;
    run_frame(100, 1, 40);
    // R4: start and byte together, then saturation
    cyc(1, 1, 0, 0, "R4");
    for (int i = 0; i < 2060; i++) cyc(1, 0, 0, 0, mode_tag());
    check("R4", int'(bytes), 2047);

    // constrained random frames over all modes
    for (int f = 0; f < 60; f++) begin
      cfg_write(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R2");
      hd = 1'($urandom_range(0, 1));
      ra = 1'($urandom_range(0, 1));
      run_frame($urandom_range(1, 150), 1'($urandom_range(0, 1)),
                ($urandom_range(0, 3) == 0) ? $urandom_range(1, 120) : 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule